// File: doc/BRIEF.md
# Selectable Status Readback Port

This block holds two small CPU-visible registers for a display controller. The selector register stores a code written by the CPU. A read of the selector port returns one live status bit in bit 0, and the code stored earlier decides which status bit that is. Bit 1 of the same read always carries the current fast graphics clock flag. A code the block does not recognise reads back as all ones.

The scan-rate register holds the horizontal scan-rate choice. The CPU can read it back and write it. A write that changes the stored bit raises a one-cycle pulse, and the video timing logic uses that pulse to set itself up again. A write of the value already stored causes nothing. The status bits are live mode flags from the command decoder and are sampled at the moment of the read.

Top module: `stat_readback_port`

## Requirements
- R1: After reset the selector code is 0 and the scan rate is 0 (24.83 kHz). A selector-port read then gives 0xFF, a scan-port read gives 0x00, and `rate_chg_o` is low.
- R2: A write to the selector port (`addr_i`=0) stores all 8 bits of `wdata_i` as the selector code. It leaves the scan rate unchanged and raises no pulse.
- R3: With selector code 1, bit 0 of a selector-port read is 1, meaning colour display.
- R4: With selector code 2, bit 0 is `odd_hide_i`. With code 3, bit 0 is `disp_en_i`. With code 4, bit 0 is `analog_pal_i`. Bits 7..2 read 0 for all three codes.
- R5: Every other selector code, 0 and 5..255 included, reads 0xFF.
- R6: Bit 1 of every selector-port read is the base value ORed with `clk5_i`.
- R7: A scan-port read (`addr_i`=1) returns the stored rate in bit 0, where 1 means 31.47 kHz. Bits 7..1 read 0.
- R8: A scan-port write stores `wdata_i[0]` as the rate. If the new bit differs from the stored one, `rate_chg_o` is high for the cycle that follows the write edge.
- R9: `rate_chg_o` stays low after a scan-port write of the value already stored, and in any cycle not preceded by a changing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0 selects the selector port, 1 selects the scan-rate port |
| wdata_i | input | 8 | Write data |
| odd_hide_i | input | 1 | Odd-raster hide flag |
| disp_en_i | input | 1 | Display enable flag |
| analog_pal_i | input | 1 | Analog palette flag |
| clk5_i | input | 1 | Fast graphics clock flag |
| rdata_o | output | 8 | Read data for the port chosen by `addr_i` (combinational) |
| rate_o | output | 1 | Stored scan-rate bit |
| rate_chg_o | output | 1 | One-cycle pulse when the scan rate changes |

## Verification
A corrupted selector code shows up on the first selector-port read after the write that set it. It can appear as a wrong flag in bit 0, or as 0xFF where a known code was expected, or the other way round. A wrong scan-rate bit appears on the next scan-port read. A broken change detector gives a missing or extra pulse exactly one cycle after the write edge. The bench therefore compares every read and the pulse on every cycle against a model of the two registers.

// File: rtl/stat_rb_pkg.sv
package stat_rb_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [DATA_W-1:0] SEL_COLOR  = 8'd1;
  localparam logic [DATA_W-1:0] SEL_ODD    = 8'd2;
  localparam logic [DATA_W-1:0] SEL_DISP   = 8'd3;
  localparam logic [DATA_W-1:0] SEL_ANALOG = 8'd4;

  typedef struct packed {
    logic odd_hide;
    logic disp_en;
    logic analog;
    logic clk5;
  } mode_flags_t;
endpackage

// File: rtl/stat_sel_reg.sv
module stat_sel_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/stat_sel_mux.sv
module stat_sel_mux
  import stat_rb_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] sel_i,
  input  mode_flags_t  flags_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] base;
  logic         known;
  logic         bit0;

  always_comb begin
    known = 1'b1;
    bit0  = 1'b0;
    unique case (sel_i)
      SEL_COLOR:  bit0 = 1'b1;
      SEL_ODD:    bit0 = flags_i.odd_hide;
      SEL_DISP:   bit0 = flags_i.disp_en;
      SEL_ANALOG: bit0 = flags_i.analog;
      default:    known = 1'b0;
    endcase
    base = known ? {{(W-1){1'b0}}, bit0} : '1;
    rdata_o = base | ({{(W-1){1'b0}}, flags_i.clk5} << 1);
  end
endmodule

// File: rtl/stat_scan_rate.sv
module stat_scan_rate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic rate_o,
  output logic chg_o
);
  logic diff;
  assign diff = we_i && (d_i != rate_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o <= 1'b0;
      chg_o  <= 1'b0;
    end else begin
      chg_o <= diff;
      if (we_i) rate_o <= d_i;
    end
  end
endmodule

// File: rtl/stat_readback_port.sv
module stat_readback_port
  import stat_rb_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         odd_hide_i,
  input  logic         disp_en_i,
  input  logic         analog_pal_i,
  input  logic         clk5_i,
  output logic [W-1:0] rdata_o,
  output logic         rate_o,
  output logic         rate_chg_o
);
  logic [W-1:0] sel_q;
  logic [W-1:0] sel_rd;
  mode_flags_t  flags;

  assign flags = '{odd_hide: odd_hide_i, disp_en: disp_en_i,
                   analog: analog_pal_i, clk5: clk5_i};

  stat_sel_reg #(.W(W)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i && !addr_i),
    .d_i(wdata_i), .q_o(sel_q)
  );

  stat_sel_mux #(.W(W)) u_mux (
    .sel_i(sel_q), .flags_i(flags), .rdata_o(sel_rd)
  );

  stat_scan_rate u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i && addr_i),
    .d_i(wdata_i[0]), .rate_o(rate_o), .chg_o(rate_chg_o)
  );

  assign rdata_o = addr_i ? {{(W-1){1'b0}}, rate_o} : sel_rd;
endmodule

// File: rtl/stat_readback_port_chk.sv
module stat_readback_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_i,
  input logic         addr_i,
  input logic [W-1:0] wdata_i,
  input logic         clk5_i,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] rdata_o,
  input logic         rate_o,
  input logic         rate_chg_o
);
  // R2
  sel_write_keeps_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i) |=> ($stable(rate_o) && !rate_chg_o));

  // R5
  unknown_code_all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i && (sel_q == '0 || sel_q > W'(4))) |-> (rdata_o == '1));

  // R6
  clk5_bit_merged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i && clk5_i) |-> rdata_o[1]);

  // R7
  scan_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i |-> (rdata_o[W-1:1] == '0 && rdata_o[0] == rate_o));

  // R8
  change_pulses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && (wdata_i[0] != rate_o)) |=> rate_chg_o);

  // R9
  same_value_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && (wdata_i[0] == rate_o)) |=> !rate_chg_o);
endmodule

bind stat_readback_port stat_readback_port_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .clk5_i(clk5_i), .sel_q(sel_q), .rdata_o(rdata_o),
  .rate_o(rate_o), .rate_chg_o(rate_chg_o)
);

// File: tb/sim_stat_readback_port.sv
module sim_stat_readback_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       odd_hide_i = 1'b0, disp_en_i = 1'b0, analog_pal_i = 1'b0, clk5_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rate_o, rate_chg_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] sel_m = '0;
  logic       rate_m = 1'b0;
  logic       pulse_m = 1'b0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  stat_readback_port u0 (.*);

  function automatic logic [7:0] exp_sel(logic [7:0] s, logic oh, logic de,
                                         logic an, logic c5);
    logic [7:0] b;
    case (s)
      8'd1: b = 8'h01;
      8'd2: b = {7'd0, oh};
      8'd3: b = {7'd0, de};
      8'd4: b = {7'd0, an};
      default: b = 8'hFF;
    endcase
    return b | {6'd0, c5, 1'b0};
  endfunction

  function automatic string sel_tag(logic [7:0] s);
    if (s == 8'd1) return "R3";
    if (s >= 8'd2 && s <= 8'd4) return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle: check pulse from previous edge, drive, check reads, update model
  task automatic step(bit w, bit a, logic [7:0] d, logic [3:0] fl);
    logic [7:0] e;
    @(negedge clk_i);
    check(rate_chg_o == pulse_m, pulse_m ? "R8" : "R9", {7'd0, rate_chg_o}, {7'd0, pulse_m});
    check(rate_o == rate_m, "R2", {7'd0, rate_o}, {7'd0, rate_m});
    wr_i = w; addr_i = a; wdata_i = d;
    {odd_hide_i, disp_en_i, analog_pal_i, clk5_i} = fl;
    #1;
    if (a) begin
      e = {7'd0, rate_m};
      check(rdata_o == e, "R7", rdata_o, e);
    end else begin
      e = exp_sel(sel_m, fl[3], fl[2], fl[1], fl[0]);
      check(rdata_o == e, sel_tag(sel_m), rdata_o, e);
      check(rdata_o[1] == (e[1] | fl[0]), "R6", rdata_o, e);
    end
    pulse_m = w && a && (d[0] != rate_m);
    if (w && a) rate_m = d[0];
    if (w && !a) sel_m = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(rdata_o == 8'hFF, "R1", rdata_o, 8'hFF);
    check(rate_chg_o == 1'b0, "R1", {7'd0, rate_chg_o}, 8'h00);
    rst_ni = 1'b1;
    step(0, 1, 8'h00, 4'h0);           // R1 scan reads 0
    step(0, 0, 8'h00, 4'h1);           // R5/R6 code 0 with clk5
    // directed selector codes
    step(1, 0, 8'd1, 4'h0);
    step(0, 0, 8'h00, 4'h0);           // R3
    step(1, 0, 8'd2, 4'h8);
    step(0, 0, 8'h00, 4'h8);           // R4 odd hide
    step(1, 0, 8'd3, 4'h4);
    step(0, 0, 8'h00, 4'h5);           // R4 display enable + clk5
    step(1, 0, 8'd4, 4'h2);
    step(0, 0, 8'h00, 4'h0);           // R4 analog low
    step(0, 0, 8'h00, 4'h2);           // R4 analog high
    step(1, 0, 8'd5, 4'hF);
    step(0, 0, 8'h00, 4'h0);           // R5 code 5
    step(1, 0, 8'hFF, 4'h0);
    step(0, 0, 8'h00, 4'h0);           // R5 code 255
    // scan rate: change, same, back-to-back change
    step(1, 1, 8'hFE, 4'h0);           // bit0=0, same: R9
    step(1, 1, 8'h01, 4'h0);           // change: R8
    step(1, 1, 8'h03, 4'h0);           // same
    step(0, 1, 8'h00, 4'h0);
    step(1, 1, 8'h00, 4'h0);
    step(1, 1, 8'h01, 4'h0);
    step(1, 0, 8'd3, 4'h0);            // R2 selector write keeps rate
    step(0, 1, 8'h00, 4'h0);
    // random
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] d;
      d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 7);
      step(1'($urandom % 3 == 0), 1'($urandom), d, 4'($urandom));
    end
    step(0, 0, 8'h00, 4'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule